// File: doc/BRIEF.md
# Time-Slot Connection Lookup Engine

This block resolves which active connection, if any, owns a given stream/time-slot position on a shared time-division bus. The position is a 13-bit key. The switch can address 5120 positions, but only a few hundred connections are live at once. The engine therefore keeps a small associative array of keys, one per live connection. A separate result store sits at the same index as each key. Each result holds a pointer (tag) into a double-buffered sample memory and a handful of control bits. One control bit chooses constant-frame delay or minimum delay for the connection.

An internal scheduler divides each bus time slot into 64 core clocks. In the first 48 clocks it steps through 16 streams, and each stream gets three operations in turn: a read compare, a write compare and a host slot. The last 16 clocks are idle. In each compare cycle the caller presents a key on `lk_key`. Key matching happens in that cycle. The result store is read in the following cycle, overlapped with the next compare, so the answer comes out two cycles after the request. Host updates are written only in host slots. A request made at any other time is held and reported busy until the next host slot.

Top module: `tsx_conn_lookup`

## Requirements
- R1: `sch_phase` follows a fixed 64-clock pattern. For clock c of a slot (c = 0..63, c = 0 in the first cycle after reset): when c < 48 the phase is c mod 3 (0 read compare, 1 write compare, 2 host) and `sch_stream` is c / 3. When c >= 48 the phase is 3 (idle) and `sch_stream` is 0.
- R2: `sch_slot` increments once every 64 clocks and wraps to 0 after FRAME_SLOTS-1. `sch_frame` toggles each time `sch_slot` wraps.
- R3: Every cycle with phase 0 or 1 produces exactly one result, with `res_valid` high two cycles later and `res_dir` equal to the phase (0 read, 1 write). Idle and host cycles produce no result.
- R4: When a valid entry holds a key equal to `lk_key`, the result has `res_hit` = 1, and `res_tag` and `res_ctrl` are the values written to that entry.
- R5: When no valid entry matches, `res_hit`, `res_tag`, `res_ctrl` and `res_bank` are all 0.
- R6: If several valid entries hold the same key, the entry with the lowest index supplies the result.
- R7: An entry written with `host_vld` = 0 never matches, whatever key it holds.
- R8: A `host_req` made while `host_busy` is low is captured, and `host_busy` goes high in the next cycle. The write takes effect at the end of the next host-phase cycle, after which `host_busy` falls. A `host_req` made while `host_busy` is high is dropped.
- R9: `res_bank` is the value of `sch_frame` in the compare cycle. The exception is a read-compare hit whose `res_ctrl` bit 0 is 1 (constant delay): there `res_bank` is the inverse of that value.
- R10: After reset, all entries are invalid, `res_valid` and `host_busy` are low, and `sch_phase`, `sch_stream`, `sch_slot` and `sch_frame` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_key | input | KEY_W (13) | Stream/time-slot key compared in phase 0 and 1 cycles |
| host_req | input | 1 | Host update request |
| host_idx | input | clog2(ENTRIES) (9) | Entry index to update |
| host_key | input | KEY_W (13) | Key written to the entry |
| host_tag | input | TAG_W (10) | Sample-memory pointer written to the entry |
| host_ctrl | input | CTRL_W (4) | Control bits; bit 0 = constant delay |
| host_vld | input | 1 | Valid bit written to the entry |
| host_busy | output | 1 | A captured update is waiting for a host slot |
| sch_stream | output | clog2(STREAMS) (4) | Stream served this cycle |
| sch_phase | output | 2 | 0 read, 1 write, 2 host, 3 idle |
| sch_slot | output | clog2(FRAME_SLOTS) (7) | Local time-slot count |
| sch_frame | output | 1 | Frame parity, selects sample-memory half |
| res_valid | output | 1 | Result present |
| res_dir | output | 1 | 0 read compare, 1 write compare |
| res_hit | output | 1 | A valid entry matched |
| res_tag | output | TAG_W (10) | Tag of the matched entry |
| res_ctrl | output | CTRL_W (4) | Control bits of the matched entry |
| res_bank | output | 1 | Sample-memory half for this access |

## Verification
A key presented in compare cycle k is answered at the sampling point of cycle k+2. The bench records, for each compare it drives, an expected item stamped with that due cycle. It compares the item only when `res_valid` shows up, and flags a result that arrives early, late or not at all. The expected answer comes from a bench model of the entries. The model is updated only after `host_busy` is seen to fall, which is the cycle after the host slot that performed the write. So compares issued from that point on see the new contents. The schedule outputs are checked every cycle against a count of clocks since reset. The busy flag is checked one cycle after each request.

// File: rtl/tsx_pkg.sv
// Shared definitions for the time-slot connection lookup engine.
// Assumes: phase codes are fixed and visible at the top-level ports.
package tsx_pkg;

    typedef enum logic [1:0] {
        PH_RD   = 2'd0,
        PH_WR   = 2'd1,
        PH_HOST = 2'd2,
        PH_IDLE = 2'd3
    } phase_e;

endpackage

// File: rtl/tsx_sched.sv
// Access scheduler. Splits each bus time slot into SLOT_CLKS clocks. The
// first STREAMS*3 clocks walk the streams through read, write and host
// phases, and the rest are idle. Also counts time slots and frame parity.
// Assumes: STREAMS*3 < SLOT_CLKS; STREAMS and FRAME_SLOTS are powers of two.
module tsx_sched
    import tsx_pkg::*;
#(
    parameter int STREAMS     = 16,
    parameter int SLOT_CLKS   = 64,
    parameter int FRAME_SLOTS = 128,
    localparam int STR_W  = $clog2(STREAMS),
    localparam int SLOT_W = $clog2(FRAME_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output phase_e            phase,
    output logic [STR_W-1:0]  stream,
    output logic [SLOT_W-1:0] slot,
    output logic              frame
);

    localparam int SUB_W  = $clog2(SLOT_CLKS);
    localparam int ACTIVE = STREAMS * 3;
    localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(SLOT_CLKS - 1);
    localparam logic [SUB_W-1:0]  SUB_ACT   = SUB_W'(ACTIVE);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_SLOTS - 1);

    logic [SUB_W-1:0]  sub_q;
    logic [1:0]        op_q;
    logic [STR_W-1:0]  str_q;
    logic [SLOT_W-1:0] slot_q;
    logic              par_q;
    logic              in_active;

    assign in_active = (sub_q < SUB_ACT);

    // Advance the sub-slot, operation, stream, slot and frame counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q  <= '0;
            op_q   <= '0;
            str_q  <= '0;
            slot_q <= '0;
            par_q  <= 1'b0;
        end else if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            op_q  <= '0;
            str_q <= '0;
            if (slot_q == SLOT_LAST) begin
                slot_q <= '0;
                par_q  <= ~par_q;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end else begin
            sub_q <= sub_q + 1'b1;
            if (in_active) begin
                if (op_q == 2'd2) begin
                    op_q  <= '0;
                    str_q <= str_q + 1'b1;
                end else begin
                    op_q <= op_q + 1'b1;
                end
            end
        end
    end

    // Decode the current operation phase from the counters.
    always_comb begin
        if (!in_active)        phase = PH_IDLE;
        else if (op_q == 2'd0) phase = PH_RD;
        else if (op_q == 2'd1) phase = PH_WR;
        else                   phase = PH_HOST;
    end

    assign stream = in_active ? str_q : '0;
    assign slot   = slot_q;
    assign frame  = par_q;

endmodule

// File: rtl/tsx_cam.sv
// Key-only associative array. Stores a key and a valid bit per entry,
// compares every entry against the presented key in parallel, and
// reports the lowest-index valid match combinationally.
// Assumes: one write per cycle at most; keys are not reset, valid bits are.
module tsx_cam #(
    parameter int ENTRIES = 512,
    parameter int KEY_W   = 13,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             wr_vld,
    input  logic [KEY_W-1:0] cmp_key,
    output logic             match_hit,
    output logic [IDX_W-1:0] match_idx
);

    logic [KEY_W-1:0]   key_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] hit_vec;

    // Store the key of the addressed entry.
    always_ff @(posedge clk) begin
        if (wr_en) key_q[wr_idx] <= wr_key;
    end

    // Maintain per-entry valid bits; all cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= wr_vld;
    end

    // One equality comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = vld_q[g] && (key_q[g] == cmp_key);
    end

    // Priority encode: scan downwards so the lowest matching index is kept.
    always_comb begin
        match_hit = 1'b0;
        match_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                match_hit = 1'b1;
                match_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tsx_rfile.sv
// Result store paired index-for-index with the key array. It has one write
// port and one read port, and the read data is registered.
// Assumes: a read and write to one index in the same cycle return the old word.
module tsx_rfile #(
    parameter int ENTRIES = 512,
    parameter int W       = 14,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] mem_q [ENTRIES];

    // Write the addressed word.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    // Registered read, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem_q[rd_idx];
    end

endmodule

// File: rtl/tsx_conn_lookup.sv
// Connection lookup engine for a time-slot switch. Each compare cycle
// matches lk_key against the key array. The next cycle fetches the paired
// result word while the following compare runs. Host updates are captured
// in a single holding register and written in the next host slot.
// Assumes: the caller presents lk_key in every cycle whose phase is 0 or 1.
module tsx_conn_lookup
    import tsx_pkg::*;
#(
    parameter int ENTRIES     = 512,
    parameter int KEY_W       = 13,
    parameter int TAG_W       = 10,
    parameter int CTRL_W      = 4,
    parameter int STREAMS     = 16,
    parameter int SLOT_CLKS   = 64,
    parameter int FRAME_SLOTS = 128,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int STR_W  = $clog2(STREAMS),
    localparam int SLOT_W = $clog2(FRAME_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KEY_W-1:0]  lk_key,
    input  logic              host_req,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [KEY_W-1:0]  host_key,
    input  logic [TAG_W-1:0]  host_tag,
    input  logic [CTRL_W-1:0] host_ctrl,
    input  logic              host_vld,
    output logic              host_busy,
    output logic [STR_W-1:0]  sch_stream,
    output logic [1:0]        sch_phase,
    output logic [SLOT_W-1:0] sch_slot,
    output logic              sch_frame,
    output logic              res_valid,
    output logic              res_dir,
    output logic              res_hit,
    output logic [TAG_W-1:0]  res_tag,
    output logic [CTRL_W-1:0] res_ctrl,
    output logic              res_bank
);

    localparam int RW = TAG_W + CTRL_W;

    phase_e            phase;
    logic              is_cmp;
    logic              cam_hit;
    logic [IDX_W-1:0]  cam_idx;
    logic [RW-1:0]     rf_word;
    logic [TAG_W-1:0]  rf_tag;
    logic [CTRL_W-1:0] rf_ctrl;

    // Host holding register
    logic              pend_q;
    logic [IDX_W-1:0]  h_idx_q;
    logic [KEY_W-1:0]  h_key_q;
    logic [TAG_W-1:0]  h_tag_q;
    logic [CTRL_W-1:0] h_ctrl_q;
    logic              h_vld_q;
    logic              wr_go;

    // Pipeline stages
    logic              s1_vld, s1_hit, s1_dir, s1_par;
    logic [IDX_W-1:0]  s1_idx;
    logic              s2_vld, s2_hit, s2_dir, s2_par;

    tsx_sched #(
        .STREAMS    (STREAMS),
        .SLOT_CLKS  (SLOT_CLKS),
        .FRAME_SLOTS(FRAME_SLOTS)
    ) u_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .stream(sch_stream),
        .slot  (sch_slot),
        .frame (sch_frame)
    );

    assign sch_phase = phase;
    assign is_cmp    = (phase == PH_RD) || (phase == PH_WR);
    assign wr_go     = pend_q && (phase == PH_HOST);
    assign host_busy = pend_q;

    // Capture one host request when idle; release it after its host slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            h_idx_q  <= '0;
            h_key_q  <= '0;
            h_tag_q  <= '0;
            h_ctrl_q <= '0;
            h_vld_q  <= 1'b0;
        end else if (!pend_q) begin
            if (host_req) begin
                pend_q   <= 1'b1;
                h_idx_q  <= host_idx;
                h_key_q  <= host_key;
                h_tag_q  <= host_tag;
                h_ctrl_q <= host_ctrl;
                h_vld_q  <= host_vld;
            end
        end else if (wr_go) begin
            pend_q <= 1'b0;
        end
    end

    tsx_cam #(
        .ENTRIES(ENTRIES),
        .KEY_W  (KEY_W)
    ) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_go),
        .wr_idx   (h_idx_q),
        .wr_key   (h_key_q),
        .wr_vld   (h_vld_q),
        .cmp_key  (lk_key),
        .match_hit(cam_hit),
        .match_idx(cam_idx)
    );

    // Stage 1: hold the compare outcome and its context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_hit <= 1'b0;
            s1_dir <= 1'b0;
            s1_par <= 1'b0;
            s1_idx <= '0;
        end else begin
            s1_vld <= is_cmp;
            s1_hit <= is_cmp && cam_hit;
            s1_dir <= (phase == PH_WR);
            s1_par <= sch_frame;
            s1_idx <= cam_idx;
        end
    end

    tsx_rfile #(
        .ENTRIES(ENTRIES),
        .W      (RW)
    ) u_rfile (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_go),
        .wr_idx (h_idx_q),
        .wr_data({h_ctrl_q, h_tag_q}),
        .rd_en  (s1_vld),
        .rd_idx (s1_idx),
        .rd_data(rf_word)
    );

    // Stage 2: context travelling alongside the registered result read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            s2_hit <= 1'b0;
            s2_dir <= 1'b0;
            s2_par <= 1'b0;
        end else begin
            s2_vld <= s1_vld;
            s2_hit <= s1_hit;
            s2_dir <= s1_dir;
            s2_par <= s1_par;
        end
    end

    assign rf_tag  = rf_word[TAG_W-1:0];
    assign rf_ctrl = rf_word[RW-1:TAG_W];

    // Form the result: zero on a miss, bank steered by the delay mode.
    always_comb begin
        res_valid = s2_vld;
        res_dir   = s2_dir;
        res_hit   = s2_hit;
        res_tag   = s2_hit ? rf_tag  : '0;
        res_ctrl  = s2_hit ? rf_ctrl : '0;
        if (!s2_hit)                   res_bank = 1'b0;
        else if (!s2_dir && rf_ctrl[0]) res_bank = ~s2_par;
        else                           res_bank = s2_par;
    end

endmodule

// File: rtl/tsx_conn_lookup_chk.sv
// Property checker for the connection lookup engine, bound to every
// instance of the top module.
module tsx_conn_lookup_chk #(
    parameter int TAG_W  = 10,
    parameter int CTRL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_busy,
    input logic [1:0]        sch_phase,
    input logic              res_valid,
    input logic              res_hit,
    input logic [TAG_W-1:0]  res_tag,
    input logic [CTRL_W-1:0] res_ctrl,
    input logic              res_bank
);

    // R1
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sch_phase == 2'd0) |=> (sch_phase == 2'd1));

    // R3
    cmp_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sch_phase == 2'd0 || sch_phase == 2'd1) |-> ##2 res_valid);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sch_phase == 2'd3) |-> ##2 !res_valid);

    // R4
    hit_in_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);

    // R5
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_tag == '0 && res_ctrl == '0 && !res_bank));

    // R8
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && sch_phase == 2'd2) |=> !host_busy);

    // R8
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_busy) |-> $past(host_req));

endmodule

bind tsx_conn_lookup tsx_conn_lookup_chk #(
    .TAG_W (TAG_W),
    .CTRL_W(CTRL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_req (host_req),
    .host_busy(host_busy),
    .sch_phase(sch_phase),
    .res_valid(res_valid),
    .res_hit  (res_hit),
    .res_tag  (res_tag),
    .res_ctrl (res_ctrl),
    .res_bank (res_bank)
);

// File: tb/tsx_conn_lookup_bench.sv
module tsx_conn_lookup_bench;

    localparam int N  = 512;
    localparam int FS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] lk_key = '0;
    logic        host_req = 1'b0;
    logic [8:0]  host_idx = '0;
    logic [12:0] host_key = '0;
    logic [9:0]  host_tag = '0;
    logic [3:0]  host_ctrl = '0;
    logic        host_vld = 1'b0;
    logic        host_busy;
    logic [3:0]  sch_stream;
    logic [1:0]  sch_phase;
    logic [1:0]  sch_slot;
    logic        sch_frame;
    logic        res_valid, res_dir, res_hit, res_bank;
    logic [9:0]  res_tag;
    logic [3:0]  res_ctrl;

    tsx_conn_lookup #(.FRAME_SLOTS(FS)) u_tsx_conn_lookup (
        .clk(clk), .rst_n(rst_n), .lk_key(lk_key),
        .host_req(host_req), .host_idx(host_idx), .host_key(host_key),
        .host_tag(host_tag), .host_ctrl(host_ctrl), .host_vld(host_vld),
        .host_busy(host_busy), .sch_stream(sch_stream), .sch_phase(sch_phase),
        .sch_slot(sch_slot), .sch_frame(sch_frame), .res_valid(res_valid),
        .res_dir(res_dir), .res_hit(res_hit), .res_tag(res_tag),
        .res_ctrl(res_ctrl), .res_bank(res_bank)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int k     = 0;
    int pc    = 0;

    typedef struct {
        int        due;
        bit        dir;
        bit        hit;
        bit [9:0]  tag;
        bit [3:0]  ctrl;
        bit        bank;
        string     lab;
    } exp_t;
    exp_t q[$];

    // Reference model of the entries
    bit [12:0] m_key  [N];
    bit        m_vld  [N];
    bit [9:0]  m_tag  [N];
    bit [3:0]  m_ctrl [N];
    bit        m_pend = 0;
    bit [8:0]  p_idx, st_idx;
    bit [12:0] p_key, st_key;
    bit [9:0]  p_tag, st_tag;
    bit [3:0]  p_ctrl, st_ctrl;
    bit        p_vld, st_vld;

    bit [12:0] probe [6] = '{13'h0123, 13'h1A05, 13'h0FFF, 13'h1300, 13'h0777, 13'h1FFF};

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Clock count since reset release: the schedule position of each cycle.
    always @(posedge clk) if (rst_n) k <= k + 1;

    // Scoreboard: schedule check, model update, result monitor, then driver.
    always @(negedge clk) begin
        if (rst_n) begin
            int c, ph, st, hi;
            bit [9:0] et;
            bit [3:0] ec;
            bit par, eb;
            string lab;
            exp_t e;
            c  = k % 64;
            ph = (c < 48) ? c % 3 : 3;
            st = (c < 48) ? c / 3 : 0;
            chk(sch_phase == 2'(ph), "R1", "phase", sch_phase, ph);
            chk(sch_stream == 4'(st), "R1", "stream", sch_stream, st);
            chk(sch_slot == 2'((k / 64) % FS), "R2", "slot", sch_slot, (k / 64) % FS);
            par = 1'((k / (64 * FS)) % 2);
            chk(sch_frame == par, "R2", "frame", sch_frame, par);

            if (host_busy && !m_pend) begin
                m_pend = 1;
                p_idx = st_idx; p_key = st_key; p_tag = st_tag;
                p_ctrl = st_ctrl; p_vld = st_vld;
            end else if (!host_busy && m_pend) begin
                m_pend = 0;
                m_key[p_idx] = p_key; m_tag[p_idx] = p_tag;
                m_ctrl[p_idx] = p_ctrl; m_vld[p_idx] = p_vld;
            end

            if (res_valid) begin
                if (q.size() == 0) begin
                    chk(0, "R3", "unexpected result", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk(e.due == k, "R3", "result cycle", k, e.due);
                    chk(res_dir == e.dir, "R3", "direction", res_dir, e.dir);
                    chk(res_hit == e.hit, e.lab, "hit", res_hit, e.hit);
                    chk(res_tag == e.tag, e.lab, "tag", res_tag, e.tag);
                    chk(res_ctrl == e.ctrl, e.lab, "ctrl", res_ctrl, e.ctrl);
                    chk(res_bank == e.bank, "R9", "bank", res_bank, e.bank);
                end
            end else if (q.size() > 0 && q[0].due <= k) begin
                chk(0, "R3", "missing result", 0, 1);
                void'(q.pop_front());
            end

            if (ph == 0 || ph == 1) begin
                lk_key = probe[pc % 6];
                pc++;
                hi = -1;
                lab = "R5";
                for (int i = 0; i < N; i++) begin
                    if (m_key[i] == lk_key) begin
                        if (!m_vld[i]) lab = "R7";
                        else if (hi < 0) hi = i;
                        else lab = "R6";
                    end
                end
                if (hi >= 0) begin
                    et = m_tag[hi]; ec = m_ctrl[hi];
                    eb = (ph == 0 && ec[0]) ? ~par : par;
                    if (lab == "R5") lab = "R4";
                end else begin
                    et = '0; ec = '0; eb = 1'b0;
                end
                e.due = k + 2; e.dir = (ph == 1); e.hit = (hi >= 0);
                e.tag = et; e.ctrl = ec; e.bank = eb; e.lab = lab;
                q.push_back(e);
            end
        end
    end

    // One host update; optionally a second request while busy (must be dropped).
    task automatic host_op(input bit [8:0] idx, input bit [12:0] key, input bit [9:0] tag,
                           input bit [3:0] ctrl, input bit vld, input bit extra);
        int c;
        st_idx = idx; st_key = key; st_tag = tag; st_ctrl = ctrl; st_vld = vld;
        @(negedge clk);
        host_req = 1; host_idx = idx; host_key = key;
        host_tag = tag; host_ctrl = ctrl; host_vld = vld;
        @(negedge clk);
        chk(host_busy == 1'b1, "R8", "busy after request", host_busy, 1);
        if (extra) begin
            host_idx = 9'd3; host_key = 13'h0777; host_tag = 10'h0EE;
            host_ctrl = 4'h1; host_vld = 1'b1;
            @(negedge clk);
        end
        host_req = 0;
        while (host_busy) @(negedge clk);
        c = (k - 1) % 64;
        chk(c < 48 && c % 3 == 2, "R8", "write slot offset", c, 2);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R10", "res_valid in reset", res_valid, 0);
        chk(host_busy == 1'b0, "R10", "host_busy in reset", host_busy, 0);
        chk(sch_phase == 2'd0, "R10", "phase in reset", sch_phase, 0);
        chk(sch_slot == 2'd0 && !sch_frame, "R10", "slot/frame in reset", sch_slot, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (100) @(negedge clk);
        host_op(9'd5,   13'h0123, 10'h02A, 4'b0001, 1'b1, 1'b0);
        host_op(9'd9,   13'h0123, 10'h155, 4'b1010, 1'b1, 1'b0);
        host_op(9'd7,   13'h0FFF, 10'h3FF, 4'b0110, 1'b1, 1'b0);
        host_op(9'd2,   13'h1A05, 10'h011, 4'b0001, 1'b0, 1'b0);
        host_op(9'd511, 13'h1FFF, 10'h200, 4'b1001, 1'b1, 1'b0);
        repeat (300) @(negedge clk);
        host_op(9'd0,   13'h1300, 10'h0AB, 4'b0000, 1'b1, 1'b1);
        repeat (150) @(negedge clk);
        host_op(9'd5,   13'h0123, 10'h000, 4'b0000, 1'b0, 1'b0);
        repeat (300) @(negedge clk);
        host_op(9'd4,   13'h1A05, 10'h0C3, 4'b0011, 1'b1, 1'b0);
        repeat (200) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule